// File: doc/BRIEF.md
# AHB-Lite Memory Subordinate with Wait States

This block is a single AHB-Lite subordinate placed in front of a small internal word memory. It accepts byte, halfword and word reads and writes. Every valid transfer has its data phase stretched by a fixed, parameter-set number of wait cycles. Transfers that fall inside a configurable forbidden address window, that use an unsupported size, or that are misaligned are refused with the two-cycle error response.

The block follows the pipelined timing of the bus. Address and control are captured at the end of the address phase. Write data is taken from the bus in the later data phase and stored at the captured address, not at whatever address the manager is already driving for its next transfer. Idle and busy cycles are acknowledged with OKAY and do not touch memory. A write that ends in error leaves memory unchanged.

Top module: `ahbl_wait_mem`

## Requirements
- R1: A transfer is taken when `sel_i` is high, `trans_i` is 2'b10 (NONSEQ) or 2'b11 (SEQ), and `ready_i` is high at the clock edge. With `WAIT_CYC` > 0, `readyout_o` is low in the following cycle.
- R2: Cycles where `sel_i` is low, or where `trans_i` is 2'b00 (IDLE) or 2'b01 (BUSY), do not change memory. The next cycle is answered with `readyout_o` high and `resp_o` low (OKAY).
- R3: Write data is sampled from `wdata_i` in the completing cycle of the data phase. It is stored at the address captured in the address phase, even when the bus already carries a different address.
- R4: A transfer without error holds `readyout_o` low for exactly `WAIT_CYC` cycles and then completes with `readyout_o` high and `resp_o` low. A `WAIT_CYC` of 0 completes the transfer in the first data-phase cycle.
- R5: An error response lasts two cycles. In the first, `resp_o` is 1 and `readyout_o` is 0. In the second, `resp_o` is 1 and `readyout_o` is 1. No wait states are added before an error.
- R6: A transfer is in error when any of these holds: its byte address lies in [`BAD_LO`, `BAD_HI`]; `size_i` is greater than 2 (encodings: 0 byte, 1 halfword, 2 word); or the address is not a multiple of 2^`size_i`.
- R7: A write that completes with the error response does not modify memory.
- R8: Memory is little-endian. A byte write updates only lane `addr[1:0]` (bits 8*lane+7 to 8*lane). A halfword write updates only lanes `addr[1]*2` and `addr[1]*2+1`. A word write updates all four lanes.
- R9: A read returns the whole word at `addr[7:2]` on `rdata_o` in its completing cycle. At all other times `rdata_o` is zero. After reset, `readyout_o` is 1, `resp_o` is 0, and every memory word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Subordinate select |
| addr_i | input | ADDR_W | Byte address of the address phase |
| trans_i | input | 2 | Transfer type: 00 idle, 01 busy, 10 nonseq, 11 seq |
| write_i | input | 1 | 1 for write, 0 for read |
| size_i | input | 3 | Log2 of the byte count |
| wdata_i | input | DATA_W | Write data of the data phase |
| ready_i | input | 1 | Bus-level ready: previous data phase completes |
| rdata_o | output | DATA_W | Read data, valid in the completing cycle |
| readyout_o | output | 1 | Low to stretch this block's data phase |
| resp_o | output | 1 | 1 for ERROR, 0 for OKAY |

## Verification
A captured address or size that is wrong shows up at a later point. The data lands in the wrong word or lanes, and a read-back of that word reveals it. The pipelined back-to-back write pair is the case that separates the captured address from the one live on the bus. A wrong wait counter or error state shows up at once as `readyout_o` or `resp_o` taking the wrong value in a specific data-phase cycle, so each transfer checks the ready pattern cycle by cycle. A failed write that still reaches memory only shows up on a later read of that word, so every error write is followed by reads.

// File: rtl/ahbl_wait_mem.sv
module ahbl_wait_mem #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int WAIT_CYC = 2,
  parameter int BAD_LO   = 'hC0,
  parameter int BAD_HI   = 'hDF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        trans_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              readyout_o,
  output logic              resp_o
);
  localparam int NB    = DATA_W / 8;
  localparam int LW    = $clog2(NB);
  localparam int WORDS = 2 ** (ADDR_W - LW);
  localparam int CW    = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1;

  logic [DATA_W-1:0] mem [WORDS];

  logic              dp_v, dp_err, dp_err2, dp_wr;
  logic [ADDR_W-1:0] dp_addr;
  logic [2:0]        dp_size;
  logic [CW-1:0]     cnt;

  logic take, bad_win, bad_size, misal, bad;
  logic done_ok;
  logic [NB-1:0] be;

  assign take     = sel_i & trans_i[1] & ready_i;
  assign bad_win  = (int'(addr_i) >= BAD_LO) && (int'(addr_i) <= BAD_HI);
  assign bad_size = int'(size_i) > LW;
  assign misal    = |(addr_i[LW-1:0] & LW'((32'd1 << size_i) - 32'd1));
  assign bad      = bad_win | bad_size | misal;

  assign readyout_o = !dp_v ? 1'b1 : (dp_err ? dp_err2 : (cnt == '0));
  assign resp_o     = dp_v & dp_err;
  assign done_ok    = dp_v & ~dp_err & (cnt == '0);
  assign rdata_o    = (done_ok & ~dp_wr) ? mem[dp_addr[ADDR_W-1:LW]] : '0;

  always_comb begin
    be = NB'((32'd1 << (32'd1 << dp_size)) - 32'd1) << dp_addr[LW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_v    <= 1'b0;
      dp_err  <= 1'b0;
      dp_err2 <= 1'b0;
      dp_wr   <= 1'b0;
      dp_addr <= '0;
      dp_size <= '0;
      cnt     <= '0;
    end else if (take) begin
      dp_v    <= 1'b1;
      dp_err  <= bad;
      dp_err2 <= 1'b0;
      dp_wr   <= write_i;
      dp_addr <= addr_i;
      dp_size <= size_i;
      cnt     <= CW'(WAIT_CYC);
    end else if (dp_v && readyout_o) begin
      dp_v    <= 1'b0;
    end else if (dp_v) begin
      if (dp_err) dp_err2 <= 1'b1;
      else        cnt     <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (done_ok && dp_wr) begin
      for (int l = 0; l < NB; l++)
        if (be[l]) mem[dp_addr[ADDR_W-1:LW]][l*8 +: 8] <= wdata_i[l*8 +: 8];
    end
  end
endmodule

// File: rtl/ahbl_wait_mem_chk.sv
module ahbl_wait_mem_chk #(
  parameter int WAIT_CYC = 2,
  parameter int DATA_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_i,
  input logic [1:0]        trans_i,
  input logic              ready_i,
  input logic              readyout_o,
  input logic              resp_o,
  input logic [DATA_W-1:0] rdata_o
);
  logic [7:0] lowcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lowcnt <= '0;
    else if (readyout_o)  lowcnt <= '0;
    else if (lowcnt != 8'hFF) lowcnt <= lowcnt + 1'b1;
  end

  p_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && trans_i[1] && ready_i && WAIT_CYC > 0) |=> !readyout_o);

  p_idle_okay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && !(sel_i && trans_i[1])) |=> (readyout_o && !resp_o));

  p_wait_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (readyout_o && !resp_o && lowcnt != 0) |-> (int'(lowcnt) == WAIT_CYC));

  p_err_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_o && !readyout_o) |=> (resp_o && readyout_o));

  p_err_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_o && readyout_o) |-> (lowcnt == 1));

  p_rdata_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !readyout_o |-> (rdata_o == '0));
endmodule

bind ahbl_wait_mem ahbl_wait_mem_chk #(.WAIT_CYC(WAIT_CYC), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .trans_i(trans_i), .ready_i(ready_i),
  .readyout_o(readyout_o), .resp_o(resp_o), .rdata_o(rdata_o)
);

// File: tb/ahbl_wait_mem_tb.sv
module ahbl_wait_mem_tb;
  localparam int WAITS = 2;
  logic clk = 0, rst_n = 0;
  logic sel = 0, wr = 0;
  logic [7:0] addr = 0;
  logic [1:0] trans = 0;
  logic [2:0] size = 0;
  logic [31:0] wdata = 0, rdata;
  logic rdy, resp;
  int total = 0, bad = 0;
  logic [7:0] mdl [256];

  always #5 clk = ~clk;

  ahbl_wait_mem #(.WAIT_CYC(WAITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .addr_i(addr), .trans_i(trans),
    .write_i(wr), .size_i(size), .wdata_i(wdata), .ready_i(rdy),
    .rdata_o(rdata), .readyout_o(rdy), .resp_o(resp)
  );

  function automatic bit exp_err(input [7:0] a, input [2:0] sz);
    if (sz > 2) return 1;
    if ((a & ((8'd1 << sz) - 8'd1)) != 0) return 1;
    return (a >= 8'hC0 && a <= 8'hDF);
  endfunction

  function automatic [31:0] exp_word(input [7:0] a);
    logic [7:0] b;
    b = a & 8'hFC;
    return {mdl[b+3], mdl[b+2], mdl[b+1], mdl[b]};
  endfunction

  task automatic chk(input bit ok, input string req, input [31:0] act, input [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input [7:0] a, input [2:0] sz, input [31:0] d);
    for (int k = 0; k < (1 << sz); k++) mdl[a + k[7:0]] = d[8*(a[1:0]+k) +: 8];
  endtask

  // data phase checks; entered at the negedge after the address was taken
  task automatic data_phase(input bit w, input [7:0] a, input [2:0] sz, input [31:0] d);
    if (exp_err(a, sz)) begin
      chk(resp && !rdy, "R5 err first", {30'd0, resp, rdy}, 32'h2);
      @(negedge clk);
      chk(resp && rdy, "R5 err second", {30'd0, resp, rdy}, 32'h3);
    end else begin
      for (int i = 0; i < WAITS; i++) begin
        chk(!rdy && !resp && rdata == 0, "R4 wait", {30'd0, resp, rdy}, 32'h0);
        @(negedge clk);
      end
      chk(rdy && !resp, "R4 complete", {30'd0, resp, rdy}, 32'h1);
      if (!w) chk(rdata == exp_word(a), "R9 read", rdata, exp_word(a));
      else apply(a, sz, d);
    end
  endtask

  task automatic xfer(input bit w, input [7:0] a, input [2:0] sz, input [31:0] d);
    @(negedge clk);
    sel = 1; trans = 2'b10; wr = w; addr = a; size = sz;
    @(negedge clk);
    sel = 0; trans = 2'b00; addr = ~a; wr = ~w; wdata = d;
    data_phase(w, a, sz, d);
  endtask

  task automatic rd_chk(input [7:0] a, input string req);
    @(negedge clk);
    sel = 1; trans = 2'b10; wr = 0; addr = a; size = 3'd2;
    @(negedge clk);
    sel = 0; trans = 2'b00;
    for (int i = 0; i < WAITS; i++) @(negedge clk);
    chk(rdata == exp_word(a), req, rdata, exp_word(a));
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rdy && !resp && rdata == 0, "R9 reset", {30'd0, resp, rdy}, 32'h1);
    rd_chk(8'h10, "R9 reset memory zero");

    // R8 byte and halfword lanes
    xfer(1, 8'h20, 2, 32'h11223344);
    xfer(1, 8'h21, 0, 32'h0000AA00);
    rd_chk(8'h20, "R8 byte lane 1");
    xfer(1, 8'h22, 1, 32'hBEEF0000);
    rd_chk(8'h20, "R8 halfword upper");
    xfer(1, 8'h23, 0, 32'h77000000);
    rd_chk(8'h20, "R8 byte lane 3");

    // R6/R7 errors: window, misaligned, oversize
    xfer(1, 8'hC4, 2, 32'hDEADBEEF);
    xfer(1, 8'h21, 1, 32'hFFFFFFFF);
    xfer(1, 8'h22, 2, 32'hFFFFFFFF);
    xfer(1, 8'h20, 3, 32'hFFFFFFFF);
    rd_chk(8'h20, "R7 failed write no change");
    xfer(0, 8'hDC, 2, 0);

    // R2 busy and unselected cycles
    @(negedge clk);
    sel = 1; trans = 2'b01; wr = 1; addr = 8'h20; size = 2; wdata = 32'h0;
    @(negedge clk);
    chk(rdy && !resp, "R2 busy okay", {30'd0, resp, rdy}, 32'h1);
    sel = 0; trans = 2'b10;
    @(negedge clk);
    chk(rdy && !resp, "R2 unselected okay", {30'd0, resp, rdy}, 32'h1);
    trans = 2'b00;
    rd_chk(8'h20, "R2 no memory change");

    // R3/R1 pipelined back-to-back writes
    @(negedge clk);
    sel = 1; trans = 2'b10; wr = 1; addr = 8'h40; size = 2;
    @(negedge clk);
    chk(!rdy, "R1 taken", {31'd0, rdy}, 32'h0);
    addr = 8'h44; trans = 2'b11; wdata = 32'hA5A5_0001;
    while (!rdy) @(negedge clk);
    @(negedge clk);
    apply(8'h40, 2, 32'hA5A5_0001);
    sel = 0; trans = 2'b00; addr = 8'h40; wdata = 32'h5A5A_0002;
    data_phase(1, 8'h44, 2, 32'h5A5A_0002);
    rd_chk(8'h40, "R3 first of pair");
    rd_chk(8'h44, "R3 second of pair");

    // random mix
    void'($urandom(32'h1234_5678));
    for (int n = 0; n < 300; n++) begin
      logic [7:0] ra;
      logic [2:0] rs;
      ra = 8'($urandom);
      rs = ($urandom % 8 == 0) ? 3'd3 : 3'($urandom % 3);
      if ($urandom % 2 == 0) ra = ra & ~((8'd1 << rs) - 8'd1);
      xfer($urandom % 2 == 1, ra, rs, $urandom);
    end
    for (int a = 0; a < 256; a += 4) rd_chk(a[7:0], "R7 R8 final memory");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule